// File: doc/BRIEF.md
# Stallable Fetch-and-Rotate Path

This block sits in front of the processing element of a row-layered iterative decoder. Each cycle it can accept one control word. The word carries a column read address, a rotation amount and a valid flag. The block issues the address to a synchronous message memory and receives the read vector one clock later. It then rotates the vector cyclically across its lanes and registers the result before it presents the vector to the processing element. The rotator has a configurable number of pipeline stages, from 0 to 3.

A bypass input lets the processing element consume its own fed-back output instead of fresh memory data. While bypass is high, every register on the fetch-and-rotate path holds its value: the address, the delayed rotation amount, the rotator stages and the output register. The memory read enable is also dropped. Vectors already in flight therefore wait, and when bypass falls they continue in order with nothing lost or repeated.

Top module: `rot_fetch_path`

## Requirements
- R1: While reset is asserted and after its release, with no word yet accepted, `pe_in_valid` is 0 and `mem_raddr` is 0.
- R2: On every clock edge where `bypass` is low, `mem_raddr` takes the value of `cw_addr`, whether or not `cw_valid` is set.
- R3: `mem_ren` equals the inverse of `bypass`. The memory updates its read data only on an edge where `mem_ren` is high. While `bypass` is high, `mem_raddr` holds its value.
- R4: The vector holds LANES lanes of MSG_W bits, and lane i sits at bits [i*MSG_W +: MSG_W]. Rotation by r places input lane (i + r) mod LANES at output lane i. Rotations 0 and LANES-1 both behave this way.
- R5: A word accepted on an edge with `bypass` low appears on `pe_in` with `pe_in_valid` high after exactly 2 + ROT_STAGES further edges on which `bypass` is low. It carries the rotated contents of the memory word at its address.
- R6: Words accepted back to back with different rotation amounts each come out with their own rotation amount.
- R7: Bypass of any length freezes every stage. Words in flight resume in order, with none lost or duplicated.
- R8: While `bypass` is high, `pe_in` equals `pe_fb` and `pe_in_valid` is 0.
- R9: An edge with `bypass` low and `cw_valid` low inserts a bubble: the matching output slot has `pe_in_valid` low.
- R10: Control words presented while `bypass` is high are ignored and never reach the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_valid | input | 1 | Control word carries a real column |
| cw_addr | input | ADDR_W | Column read address |
| cw_rot | input | $clog2(LANES) | Rotation amount, 0 to LANES-1 |
| bypass | input | 1 | Select fed-back PE output and stall the path |
| mem_raddr | output | ADDR_W | Read address to the message memory |
| mem_ren | output | 1 | Read enable to the message memory |
| mem_rdata | input | LANES*MSG_W | Read data, one clock after the address |
| pe_fb | input | LANES*MSG_W | Processing-element output fed back |
| pe_in | output | LANES*MSG_W | Vector presented to the processing element |
| pe_in_valid | output | 1 | `pe_in` carries a rotated memory vector |

## Verification
Two events can fall in the same cycle. One is bypass rising just as a valid vector reaches the output register. The other is a new control word presented on the edge where the stall begins. In either case the stalled vector must surface intact after the stall, and the word presented under bypass must vanish. The bench provokes both with directed bursts of bypass of length 1, 2 and 3 while words stream in. It then follows with a long random mix of bypass and bubbles. Each output slot is judged against a history indexed by the count of unstalled edges, so any loss, duplication or misalignment of data, rotation or valid shows up as a mismatch.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
    // cyclic source lane for output lane i under a rotation of r
    function automatic int src_lane(input int i, input int r, input int lanes);
        return (i + r) % lanes;
    endfunction
endpackage

// File: rtl/rfp_rotator.sv
module rfp_rotator #(
    parameter int LANES  = 8,
    parameter int MSG_W  = 6,
    localparam int ROT_W = $clog2(LANES),
    localparam int VEC_W = LANES * MSG_W
) (
    input  logic [VEC_W-1:0] vec_i,
    input  logic [ROT_W-1:0] rot_i,
    output logic [VEC_W-1:0] vec_o
);
    import rfp_pkg::*;

    // logarithmic rotator: level b rotates by 2**b when rot_i[b] is set
    always_comb begin
        logic [VEC_W-1:0] cur;
        logic [VEC_W-1:0] nxt;
        cur = vec_i;
        for (int b = 0; b < ROT_W; b++) begin
            nxt = cur;
            if (rot_i[b]) begin
                for (int i = 0; i < LANES; i++) begin
                    nxt[i*MSG_W +: MSG_W] = cur[src_lane(i, 1 << b, LANES)*MSG_W +: MSG_W];
                end
            end
            cur = nxt;
        end
        vec_o = cur;
    end
endmodule

// File: rtl/rfp_pipe_stage.sv
module rfp_pipe_stage #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] d_data,
    input  logic             d_valid,
    output logic [WIDTH-1:0] q_data,
    output logic             q_valid
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             valid;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (en) begin
            s_d.data  = d_data;
            s_d.valid = d_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_data  = s_q.data;
    assign q_valid = s_q.valid;

    // R7
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(q_data) && $stable(q_valid)));
endmodule

// File: rtl/rot_fetch_path.sv
module rot_fetch_path #(
    parameter int LANES      = 8,
    parameter int MSG_W      = 6,
    parameter int ADDR_W     = 5,
    parameter int ROT_STAGES = 2,
    localparam int ROT_W     = $clog2(LANES),
    localparam int VEC_W     = LANES * MSG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_valid,
    input  logic [ADDR_W-1:0] cw_addr,
    input  logic [ROT_W-1:0]  cw_rot,
    input  logic              bypass,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              mem_ren,
    input  logic [VEC_W-1:0]  mem_rdata,
    input  logic [VEC_W-1:0]  pe_fb,
    output logic [VEC_W-1:0]  pe_in,
    output logic              pe_in_valid
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ROT_W-1:0]  rot0;
        logic              v0;
        logic [ROT_W-1:0]  rot1;
        logic              v1;
        logic [VEC_W-1:0]  out_data;
        logic              out_v;
    } path_t;

    path_t r_d, r_q;
    logic  adv;

    logic [VEC_W-1:0] chain_data  [0:ROT_STAGES];
    logic             chain_valid [0:ROT_STAGES];

    assign adv = ~bypass;

    rfp_rotator #(.LANES(LANES), .MSG_W(MSG_W)) u_rot (
        .vec_i (mem_rdata),
        .rot_i (r_q.rot1),
        .vec_o (chain_data[0])
    );
    assign chain_valid[0] = r_q.v1;

    for (genvar k = 0; k < ROT_STAGES; k++) begin : g_stage
        rfp_pipe_stage #(.WIDTH(VEC_W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (adv),
            .d_data  (chain_data[k]),
            .d_valid (chain_valid[k]),
            .q_data  (chain_data[k+1]),
            .q_valid (chain_valid[k+1])
        );
    end

    always_comb begin
        r_d = r_q;
        if (adv) begin
            r_d.addr     = cw_addr;
            r_d.rot0     = cw_rot;
            r_d.v0       = cw_valid;
            r_d.rot1     = r_q.rot0;
            r_d.v1       = r_q.v0;
            r_d.out_data = chain_data[ROT_STAGES];
            r_d.out_v    = chain_valid[ROT_STAGES];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_raddr   = r_q.addr;
    assign mem_ren     = adv;
    assign pe_in       = bypass ? pe_fb : r_q.out_data;
    assign pe_in_valid = r_q.out_v & adv;

    // R3
    raddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> $stable(mem_raddr));

    // R10
    capture_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> ($stable(r_q.rot0) && $stable(r_q.v0)));

    // R5
    valid_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cw_valid) ##1 adv |=> r_q.v1);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> ($stable(r_q.out_data) && $stable(r_q.out_v)));
endmodule

// File: tb/tb_rot_fetch_path.sv
module tb_rot_fetch_path;
    localparam int LANES = 8;
    localparam int MSG_W = 6;
    localparam int ADDR_W = 5;
    localparam int STG = 2;
    localparam int ROT_W = $clog2(LANES);
    localparam int VEC_W = LANES * MSG_W;
    localparam int LAT = 2 + STG;
    localparam int HDEPTH = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cw_valid = 1'b0;
    logic [ADDR_W-1:0] cw_addr = '0;
    logic [ROT_W-1:0] cw_rot = '0;
    logic bypass = 1'b0;
    logic [ADDR_W-1:0] mem_raddr;
    logic mem_ren;
    logic [VEC_W-1:0] mem_rdata = '0;
    logic [VEC_W-1:0] pe_fb = '0;
    logic [VEC_W-1:0] pe_in;
    logic pe_in_valid;

    int checks = 0;
    int fails = 0;
    int ac = 0;
    string cur_tag = "R5";
    logic hv [0:HDEPTH-1];
    logic [ADDR_W-1:0] ha [0:HDEPTH-1];
    logic [ROT_W-1:0] hr [0:HDEPTH-1];

    always #2 clk = ~clk;

    rot_fetch_path #(.LANES(LANES), .MSG_W(MSG_W), .ADDR_W(ADDR_W), .ROT_STAGES(STG)) dut (
        .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_rot(cw_rot),
        .bypass(bypass), .mem_raddr(mem_raddr), .mem_ren(mem_ren), .mem_rdata(mem_rdata),
        .pe_fb(pe_fb), .pe_in(pe_in), .pe_in_valid(pe_in_valid)
    );

    function automatic logic [VEC_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        logic [VEC_W-1:0] w;
        for (int j = 0; j < LANES; j++) w[j*MSG_W +: MSG_W] = MSG_W'(int'(a) * 7 + j * 13 + 1);
        return w;
    endfunction

    function automatic logic [VEC_W-1:0] rotl(input logic [VEC_W-1:0] v, input int r);
        logic [VEC_W-1:0] o;
        for (int i = 0; i < LANES; i++) o[i*MSG_W +: MSG_W] = v[((i + r) % LANES)*MSG_W +: MSG_W];
        return o;
    endfunction

    // synchronous memory model with read enable
    always @(posedge clk) if (mem_ren) mem_rdata <= mem_word(mem_raddr);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic [ADDR_W-1:0] ea;
        int idx;
        logic ev;
        logic [VEC_W-1:0] ed;
        chk(mem_ren == !bypass, "R3", 64'(mem_ren), 64'(!bypass));
        ea = (ac >= 1) ? ha[ac] : '0;
        chk(mem_raddr == ea, bypass ? "R3" : "R2", 64'(mem_raddr), 64'(ea));
        if (bypass) begin
            chk(pe_in == pe_fb, "R8", 64'(pe_in), 64'(pe_fb));
            chk(pe_in_valid == 1'b0, "R8", 64'(pe_in_valid), 64'd0);
        end else begin
            idx = ac - LAT;
            ev = (idx >= 1) ? hv[idx] : 1'b0;
            chk(pe_in_valid == ev, cur_tag, 64'(pe_in_valid), 64'(ev));
            if (ev) begin
                ed = rotl(mem_word(ha[idx]), int'(hr[idx]));
                chk(pe_in == ed, cur_tag, 64'(pe_in), 64'(ed));
            end
        end
    endtask

    task automatic step(input logic byp, input logic v, input int a, input int r);
        bypass = byp;
        cw_valid = v;
        cw_addr = ADDR_W'(a);
        cw_rot = ROT_W'(r);
        pe_fb = {$urandom, $urandom};
        #1;
        check_outputs();
        if (!byp) begin
            hv[ac+1] = v;
            ha[ac+1] = ADDR_W'(a);
            hr[ac+1] = ROT_W'(r);
        end
        @(posedge clk);
        if (!byp) ac++;
        @(negedge clk);
    endtask

    task automatic drain();
        for (int i = 0; i < LAT + 2; i++) step(1'b0, 1'b0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pe_in_valid == 1'b0, "R1", 64'(pe_in_valid), 64'd0);
        chk(mem_raddr == '0, "R1", 64'(mem_raddr), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(pe_in_valid == 1'b0, "R1", 64'(pe_in_valid), 64'd0);
        @(negedge clk);

        // R4: extreme rotation amounts
        cur_tag = "R4";
        step(1'b0, 1'b1, 3, 0);
        step(1'b0, 1'b1, 9, LANES - 1);
        step(1'b0, 1'b1, 31, 1);
        drain();

        // R6: back-to-back with every rotation amount
        cur_tag = "R6";
        for (int r = 0; r < LANES; r++) step(1'b0, 1'b1, 4 + r, LANES - 1 - r);
        drain();

        // R7 and R10: bypass bursts in a stream, words offered during the stall
        for (int len = 1; len <= 3; len++) begin
            cur_tag = "R7";
            for (int i = 0; i < LAT; i++) step(1'b0, 1'b1, 10 + i + len, i + len);
            cur_tag = "R10";
            for (int i = 0; i < len; i++) step(1'b1, 1'b1, 20 + i, 5);
            cur_tag = "R7";
            for (int i = 0; i < LAT; i++) step(1'b0, 1'b1, 2 + i, 3 + i);
        end
        drain();

        // R9: bubbles
        cur_tag = "R9";
        for (int i = 0; i < 12; i++) step(1'b0, i[0], i, i);
        drain();

        // R5: random mix
        cur_tag = "R5";
        for (int i = 0; i < 1200; i++)
            step(($urandom % 4) == 0, ($urandom % 4) != 0, $urandom % 32, $urandom % LANES);
        drain();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule